// File: doc/BRIEF.md
# Cycle-Count Drift Servo

This block keeps a local cycle counter locked to a remote master counter. For each bus sync event it receives a pair of timestamps: the local counter value captured at the event, and the master's counter value for the same event, taken from a sync packet. The first pair after reset, or after a forced relearn, is used only to learn a fixed offset. That offset converts local counts into master time for the rest of the run.

Every later pair yields a signed error in counts: the master value minus the converted local value. The error is clamped to 24 bits and drives a fixed-point PID loop. The loop output, centred on mid-scale and saturated, is held in a DAC code register. That DAC sets the control voltage of the tunable oscillator clocking the local counter. The full DAC code span maps onto the oscillator's pull range, about 150 ppm.

Pairs typically arrive ten times a second. A count is 31.25 ns, so the loop works in counts per 100 ms period and should settle to an error that stays within plus or minus one count.

The control sequence is a four-state machine:
- `S_LEARN` waits for the first pair and stores the offset (`learn` transition to `S_TRACK`).
- `S_TRACK` waits for a later pair and registers the clamped error (`accept` transition to `S_INTEG`).
- `S_INTEG` updates the integrator and the derivative term (`advance` transition to `S_SUM`).
- `S_SUM` forms the weighted sum and writes the DAC code (`publish` transition back to `S_TRACK`).

A clear request from any state takes the `relearn` transition to `S_LEARN`.

Top module: `drift_servo`

## Requirements
- R1: After reset `dac_code` is 32768 (mid-scale) and `offset_valid` is 0.
- R2: The first accepted pair in the learning state stores offset = master − local and sets `offset_valid` to 1. `dac_code` stays at 32768 while `offset_valid` is 0 and is not changed by the learning pair.
- R3: A later pair gives error = master − (local + offset), computed modulo 2^64 and read as signed. It is clamped to [−8388608, 8388607].
- R4: `dac_code` = saturate(32768 + ((kp·e + ki·I + kd·D) >>> 10)). Gains are signed with 10 fraction bits, so 1024 means 1.0. The shift is arithmetic and rounds toward minus infinity. The new code appears after the third rising edge, counting the edge that samples `pair_valid`.
- R5: On each update, the integrator I becomes I + e and is then clamped to [−1048576, 1048576]. The updated value is used in the same update.
- R6: The derivative D is e minus the previous update's e. It is 0 on the first update after the offset is learned.
- R7: The DAC code saturates at 0 and at 65535.
- R8: A one-cycle `offset_clear` pulse clears `offset_valid` and returns `dac_code` to 32768 after the next edge. It also zeroes the integrator and the derivative history, and the next pair is learned as a new offset.
- R9: When `offset_clear` and `pair_valid` are both high in the same cycle, the clear wins and the pair is discarded.
- R10: Pairs presented during the two processing cycles that follow an accepted pair are ignored.
- R11: `dac_code` changes only on the edge that ends `S_SUM` or on the edge that takes a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_valid | input | 1 | Timestamp pair present this cycle |
| local_ts | input | 64 | Local cycle count captured at the sync event |
| master_ts | input | 64 | Master cycle count for the same event |
| kp | input | 16 | Signed proportional gain, 10 fraction bits |
| ki | input | 16 | Signed integral gain, 10 fraction bits |
| kd | input | 16 | Signed derivative gain, 10 fraction bits |
| offset_clear | input | 1 | Force the offset to be relearned |
| offset_valid | output | 1 | Offset has been learned |
| dac_code | output | 16 | Unsigned oscillator control code |

## Verification
Two pairs of events can collide in the same cycle. The first is a relearn request arriving together with a new timestamp pair. The bench raises both inputs on one edge. It then judges the outcome at the ports: `offset_valid` must be low and the code back at mid-scale, and the next pair must be taken as a fresh offset rather than as an error sample. The second collision is a pair arriving while an earlier one is still being processed. The bench holds `pair_valid` high for three edges with differing data and checks that the code matches a model that applied only the first pair. A single pair sent afterwards confirms the loop has returned to tracking.

// File: rtl/drift_servo_pkg.sv
package drift_servo_pkg;

    typedef enum logic [1:0] {
        S_LEARN = 2'd0,
        S_TRACK = 2'd1,
        S_INTEG = 2'd2,
        S_SUM   = 2'd3
    } servo_state_t;

endpackage

// File: rtl/drift_servo_fsm.sv
module drift_servo_fsm
    import drift_servo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pair_valid,
    input  logic offset_clear,
    output logic learn_en,
    output logic err_en,
    output logic integ_en,
    output logic sum_en
);

    servo_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_LEARN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (offset_clear) begin
            state_d = S_LEARN;                  // relearn
        end else begin
            unique case (state_q)
                S_LEARN: if (pair_valid) state_d = S_TRACK;  // learn
                S_TRACK: if (pair_valid) state_d = S_INTEG;  // accept
                S_INTEG: state_d = S_SUM;                    // advance
                S_SUM:   state_d = S_TRACK;                  // publish
            endcase
        end
    end

    always_comb begin
        learn_en = 1'b0;
        err_en   = 1'b0;
        integ_en = 1'b0;
        sum_en   = 1'b0;
        if (!offset_clear) begin
            unique case (state_q)
                S_LEARN: learn_en = pair_valid;
                S_TRACK: err_en   = pair_valid;
                S_INTEG: integ_en = 1'b1;
                S_SUM:   sum_en   = 1'b1;
            endcase
        end
    end

    // R10: processing runs two fixed cycles once a pair is accepted
    p_busy_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_INTEG && !offset_clear) |=> (state_q == S_SUM));

    p_one_ctrl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({learn_en, err_en, integ_en, sum_en}));

    // R9: a clear always lands in the learning state
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        offset_clear |=> (state_q == S_LEARN));

endmodule

// File: rtl/drift_offset_err.sv
module drift_offset_err #(
    parameter int TS_W  = 64,
    parameter int ERR_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    learn_en,
    input  logic                    err_en,
    input  logic [TS_W-1:0]         local_ts,
    input  logic [TS_W-1:0]         master_ts,
    output logic                    offset_valid,
    output logic signed [ERR_W-1:0] err_q
);

    logic [TS_W-1:0]         offset_q;
    logic signed [TS_W-1:0]  diff;
    logic signed [TS_W-1:0]  e_max, e_min;
    logic signed [ERR_W-1:0] err_c;

    always_comb begin
        e_max = {{(TS_W-ERR_W+1){1'b0}}, {(ERR_W-1){1'b1}}};
        e_min = ~e_max;
        diff  = signed'(master_ts - (local_ts + offset_q));
        if (diff > e_max)
            err_c = {1'b0, {(ERR_W-1){1'b1}}};
        else if (diff < e_min)
            err_c = {1'b1, {(ERR_W-1){1'b0}}};
        else
            err_c = diff[ERR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset_q     <= '0;
            offset_valid <= 1'b0;
            err_q        <= '0;
        end else if (clr) begin
            offset_q     <= '0;
            offset_valid <= 1'b0;
        end else begin
            if (learn_en) begin
                offset_q     <= master_ts - local_ts;
                offset_valid <= 1'b1;
            end
            if (err_en) err_q <= err_c;
        end
    end

    // R2: the offset is only learned while no offset is held
    p_learn_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        offset_valid |-> !learn_en);

    // R3: the offset register holds still while tracking
    p_offset_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_valid && !clr) |=> $stable(offset_q));

endmodule

// File: rtl/drift_pid.sv
module drift_pid #(
    parameter int ERR_W   = 24,
    parameter int COEF_W  = 16,
    parameter int INT_W   = 32,
    parameter int FRAC    = 10,
    parameter int DAC_W   = 16,
    parameter int INT_LIM = 1048576
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     integ_en,
    input  logic                     sum_en,
    input  logic signed [ERR_W-1:0]  err_q,
    input  logic signed [COEF_W-1:0] kp,
    input  logic signed [COEF_W-1:0] ki,
    input  logic signed [COEF_W-1:0] kd,
    output logic [DAC_W-1:0]         dac_code
);

    localparam int SUM_W   = COEF_W + INT_W + 2;
    localparam int MID     = 1 << (DAC_W - 1);
    localparam int DAC_MAX = (1 << DAC_W) - 1;

    logic signed [INT_W-1:0] integ_q;
    logic signed [ERR_W:0]   deriv_q;
    logic signed [ERR_W-1:0] prev_q;
    logic                    first_q;

    logic signed [INT_W:0]   integ_sum, i_max, i_min;
    logic signed [INT_W-1:0] integ_c;
    logic signed [SUM_W-1:0] p_term, i_term, d_term, total, shifted, level;
    logic [DAC_W-1:0]        dac_c;

    always_comb begin
        i_max     = (INT_W+1)'(INT_LIM);
        i_min     = -i_max;
        integ_sum = (INT_W+1)'(integ_q) + (INT_W+1)'(err_q);
        if (integ_sum > i_max)      integ_c = i_max[INT_W-1:0];
        else if (integ_sum < i_min) integ_c = i_min[INT_W-1:0];
        else                        integ_c = integ_sum[INT_W-1:0];
    end

    always_comb begin
        p_term  = SUM_W'(kp) * SUM_W'(err_q);
        i_term  = SUM_W'(ki) * SUM_W'(integ_q);
        d_term  = SUM_W'(kd) * SUM_W'(deriv_q);
        total   = p_term + i_term + d_term;
        shifted = total >>> FRAC;
        level   = shifted + SUM_W'(MID);
        if (level < 0)                     dac_c = '0;
        else if (level > SUM_W'(DAC_MAX))  dac_c = DAC_MAX[DAC_W-1:0];
        else                               dac_c = level[DAC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            integ_q  <= '0;
            deriv_q  <= '0;
            prev_q   <= '0;
            first_q  <= 1'b1;
            dac_code <= MID[DAC_W-1:0];
        end else if (clr) begin
            integ_q  <= '0;
            deriv_q  <= '0;
            prev_q   <= '0;
            first_q  <= 1'b1;
            dac_code <= MID[DAC_W-1:0];
        end else begin
            if (integ_en) begin
                integ_q <= integ_c;
                deriv_q <= first_q ? '0 : ((ERR_W+1)'(err_q) - (ERR_W+1)'(prev_q));
                prev_q  <= err_q;
                first_q <= 1'b0;
            end
            if (sum_en) dac_code <= dac_c;
        end
    end

    // R5: integrator never leaves its anti-windup window
    p_integ_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_q <= INT_W'(INT_LIM)) && (integ_q >= -INT_W'(INT_LIM)));

    // R6: first update after learning carries no derivative
    p_deriv_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_en && first_q && !clr) |=> (deriv_q == 0));

    // R11: the code only moves on publish or clear
    p_dac_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sum_en && !clr) |=> $stable(dac_code));

endmodule

// File: rtl/drift_servo.sv
module drift_servo #(
    parameter int TS_W    = 64,
    parameter int ERR_W   = 24,
    parameter int COEF_W  = 16,
    parameter int INT_W   = 32,
    parameter int FRAC    = 10,
    parameter int DAC_W   = 16,
    parameter int INT_LIM = 1048576
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pair_valid,
    input  logic [TS_W-1:0]          local_ts,
    input  logic [TS_W-1:0]          master_ts,
    input  logic signed [COEF_W-1:0] kp,
    input  logic signed [COEF_W-1:0] ki,
    input  logic signed [COEF_W-1:0] kd,
    input  logic                     offset_clear,
    output logic                     offset_valid,
    output logic [DAC_W-1:0]         dac_code
);

    localparam int MID = 1 << (DAC_W - 1);

    logic learn_en, err_en, integ_en, sum_en;
    logic signed [ERR_W-1:0] err_q;

    drift_servo_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pair_valid   (pair_valid),
        .offset_clear (offset_clear),
        .learn_en     (learn_en),
        .err_en       (err_en),
        .integ_en     (integ_en),
        .sum_en       (sum_en)
    );

    drift_offset_err #(.TS_W(TS_W), .ERR_W(ERR_W)) u_err (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (offset_clear),
        .learn_en     (learn_en),
        .err_en       (err_en),
        .local_ts     (local_ts),
        .master_ts    (master_ts),
        .offset_valid (offset_valid),
        .err_q        (err_q)
    );

    drift_pid #(
        .ERR_W(ERR_W), .COEF_W(COEF_W), .INT_W(INT_W),
        .FRAC(FRAC), .DAC_W(DAC_W), .INT_LIM(INT_LIM)
    ) u_pid (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (offset_clear),
        .integ_en (integ_en),
        .sum_en   (sum_en),
        .err_q    (err_q),
        .kp       (kp),
        .ki       (ki),
        .kd       (kd),
        .dac_code (dac_code)
    );

    // R2: no steering before an offset exists
    p_mid_unlearned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !offset_valid |-> (dac_code == MID[DAC_W-1:0]));

    // R8: a clear drops the offset and recentres the code
    p_clear_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        offset_clear |=> (!offset_valid && dac_code == MID[DAC_W-1:0]));

endmodule

// File: tb/drift_servo_tb_top.sv
module drift_servo_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pair_valid = 1'b0;
    logic [63:0] local_ts = '0;
    logic [63:0] master_ts = '0;
    logic        offset_clear = 1'b0;
    logic        offset_valid;
    logic [15:0] dac_code;
    int          g_kp = 0, g_ki = 0, g_kd = 0;
    logic signed [15:0] kp, ki, kd;

    assign kp = 16'(g_kp);
    assign ki = 16'(g_ki);
    assign kd = 16'(g_kd);

    always #10 clk = ~clk;

    drift_servo dut_i (
        .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid),
        .local_ts(local_ts), .master_ts(master_ts),
        .kp(kp), .ki(ki), .kd(kd),
        .offset_clear(offset_clear), .offset_valid(offset_valid),
        .dac_code(dac_code)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // reference model state
    bit     m_learned;
    longint m_off, m_int, m_prev, m_lcnt;
    bit     m_first;
    longint m_dac;

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_learned = 0; m_off = 0; m_int = 0; m_prev = 0; m_first = 1; m_dac = 32768;
    endtask

    task automatic model_pair(longint l, longint m);
        longint e, d, s, v;
        if (!m_learned) begin
            m_off = m - l; m_learned = 1;
        end else begin
            e = m - (l + m_off);
            if (e > 8388607) e = 8388607;
            if (e < -8388608) e = -8388608;
            d = m_first ? 0 : e - m_prev;
            m_prev = e; m_first = 0;
            m_int = m_int + e;
            if (m_int > 1048576) m_int = 1048576;
            if (m_int < -1048576) m_int = -1048576;
            s = (longint'(g_kp) * e + longint'(g_ki) * m_int + longint'(g_kd) * d) >>> 10;
            v = 32768 + s;
            if (v < 0) v = 0;
            if (v > 65535) v = 65535;
            m_dac = v;
        end
    endtask

    task automatic send_raw(longint l, longint m);
        @(negedge clk);
        local_ts = 64'(l); master_ts = 64'(m); pair_valid = 1'b1;
        @(negedge clk);
        pair_valid = 1'b0;
        repeat (3) @(negedge clk);
        model_pair(l, m);
    endtask

    task automatic send_err(longint e);
        m_lcnt += 1000;
        send_raw(m_lcnt, m_lcnt + m_off + e);
    endtask

    task automatic do_clear();
        @(negedge clk);
        offset_clear = 1'b1;
        @(negedge clk);
        offset_clear = 1'b0;
        model_reset();
    endtask

    task automatic fresh(int p, int i, int d, longint base);
        g_kp = p; g_ki = i; g_kd = d;
        do_clear();
        m_lcnt += 5000;
        send_raw(m_lcnt, m_lcnt + base);
    endtask

    task automatic t_reset();
        chk("R1 dac", dac_code, 32768);
        chk("R1 valid", offset_valid, 0);
    endtask

    task automatic t_learn();
        m_lcnt = 1000;
        send_raw(1000, 5000);
        chk("R2 valid", offset_valid, 1);
        chk("R2 dac mid", dac_code, 32768);
    endtask

    task automatic t_prop();
        fresh(1024, 0, 0, 777);
        send_err(10);  chk("R4 p pos", dac_code, m_dac); chk("R3 p pos", dac_code, 32778);
        send_err(-25); chk("R4 p neg", dac_code, 32743);
        g_kp = 512;
        send_err(7);   chk("R4 p frac", dac_code, m_dac);
    endtask

    task automatic t_integral();
        fresh(0, 1024, 0, 123456);
        send_err(5);  chk("R5 i1", dac_code, 32773);
        send_err(5);  chk("R5 i2", dac_code, 32778);
        send_err(-3); chk("R5 i3", dac_code, 32775);
    endtask

    task automatic t_deriv();
        fresh(0, 0, 1024, 42);
        send_err(50); chk("R6 first zero", dac_code, 32768);
        send_err(80); chk("R6 d up", dac_code, 32798);
        send_err(20); chk("R6 d down", dac_code, m_dac);
    endtask

    task automatic t_clamp();
        fresh(1, 0, 0, 9);
        send_err(10000000);  chk("R3 clamp pos", dac_code, 40959);
        send_err(-10000000); chk("R3 clamp neg", dac_code, 24576);
    endtask

    task automatic t_windup();
        fresh(0, 1, 0, 3);
        send_err(9000000); chk("R5 windup1", dac_code, 33792);
        send_err(9000000); chk("R5 windup2", dac_code, 33792);
        send_err(-100);    chk("R5 unwind", dac_code, 33791);
    endtask

    task automatic t_sat();
        fresh(1024, 0, 0, 11);
        send_err(40000);  chk("R7 sat hi", dac_code, 65535);
        send_err(-40000); chk("R7 sat lo", dac_code, 0);
    endtask

    task automatic t_clear();
        fresh(1024, 1024, 0, 500);
        send_err(300);
        do_clear();
        chk("R8 valid low", offset_valid, 0);
        chk("R8 dac mid", dac_code, 32768);
        m_lcnt += 100;
        send_raw(m_lcnt, m_lcnt + 99999);
        chk("R8 relearn valid", offset_valid, 1);
        chk("R8 relearn dac", dac_code, 32768);
        send_err(3); chk("R8 fresh integ", dac_code, 32774);
    endtask

    task automatic t_collide();
        fresh(1024, 0, 0, 20);
        send_err(40);
        chk("R9 pre", dac_code, 32808);
        @(negedge clk);
        offset_clear = 1'b1; pair_valid = 1'b1;
        local_ts = 64'(m_lcnt + 50); master_ts = 64'(m_lcnt + 70000);
        @(negedge clk);
        offset_clear = 1'b0; pair_valid = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        chk("R9 valid low", offset_valid, 0);
        chk("R9 dac mid", dac_code, 32768);
        m_lcnt += 100;
        send_raw(m_lcnt, m_lcnt + 64);
        chk("R9 new learn dac", dac_code, 32768);
        send_err(6); chk("R9 next err", dac_code, 32774);
    endtask

    task automatic t_busy();
        fresh(1024, 0, 0, 30);
        m_lcnt += 1000;
        @(negedge clk);
        local_ts = 64'(m_lcnt); master_ts = 64'(m_lcnt + m_off + 10); pair_valid = 1'b1;
        @(negedge clk);
        master_ts = 64'(m_lcnt + m_off + 500);
        @(negedge clk);
        master_ts = 64'(m_lcnt + m_off + 900);
        @(negedge clk);
        pair_valid = 1'b0;
        model_pair(m_lcnt, m_lcnt + m_off + 10);
        repeat (3) @(negedge clk);
        chk("R10 busy drop", dac_code, m_dac);
        chk("R10 only first", dac_code, 32778);
        send_err(2); chk("R10 back to track", dac_code, 32770);
        chk("R11 held", dac_code, 32770);
    endtask

    initial begin
        model_reset();
        m_lcnt = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_learn();
        t_prop();
        t_integral();
        t_deriv();
        t_clamp();
        t_windup();
        t_sat();
        t_clear();
        t_collide();
        t_busy();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule